// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Periodic Rate Logic

This block collects the three interrupt causes of a real-time clock: a time-of-day alarm match, a periodic tick taken from a programmable divider, and the end of each once-per-second calendar update. Each cause latches its own flag in a status byte and has its own enable bit. Any flag whose enable is set raises a summary bit in that byte and drives an active-low interrupt pin. A single read of the status byte clears every flag.

The divider counts a base tick, nominally 32.768 kHz, supplied by the oscillator logic outside this block. A four-bit rate code selects the periodic period as a power of two of that tick. The same periodic event toggles a square-wave phase, so the square-wave pin runs at half the periodic rate when its own enable bit is set.

The block holds an eight-bit control word that software loads with a write strobe. The word carries the rate code, the square-wave enable and the three interrupt enables. The alarm and update-ended inputs are single-cycle pulses from the calendar logic.

Top module: `rtc_irq_rate`

## Requirements
- R1: The status byte is {IRQF, PF, AF, UF, 4'b0000}: bit 7 is the summary, bit 6 is the periodic flag, bit 5 is the alarm flag, bit 4 is the update-ended flag, and bits 3..0 always read zero.
- R2: An `alarm_i` pulse sets AF and an `update_i` pulse sets UF at the next clock edge, and each flag stays set until a status read.
- R3: For a rate code n from 1 to 15, a periodic event occurs on a tick when the number of ticks since reset, counting that tick, is a multiple of 2^(n-1). The event sets PF. Code 3 therefore gives 4 ticks (122.07 us at 32.768 kHz) and code 15 gives 16384 ticks (500 ms).
- R4: Rate code 0 produces no periodic events, so PF is never set and the square-wave pin stays low.
- R5: A cycle with `rd_i` high clears PF, AF and UF at its closing edge. A flag whose source fires in that same cycle ends up set.
- R6: IRQF is (PF & PIE) | (AF & AIE) | (UF & UIE).
- R7: `irq_n_o` is low exactly when IRQF is one.
- R8: The square-wave phase toggles on every periodic event. `sqw_o` equals that phase when the square-wave enable is set and the rate code is nonzero, and is 0 otherwise.
- R9: `ctl_we_i` loads `ctl_i` at the clock edge. The field layout is [3:0] rate code, [4] square-wave enable, [5] UIE, [6] AIE, [7] PIE. A tick in the write cycle is judged with the old rate code.
- R10: Reset (`rst_n` low, synchronous) clears every flag, the whole control word including PIE, the tick count and the square-wave phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle base-rate tick |
| alarm_i | input | 1 | One-cycle alarm-match pulse |
| update_i | input | 1 | One-cycle update-ended pulse |
| rd_i | input | 1 | Status read strobe, clears flags |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_i | input | 8 | Control word: rate, square enable, UIE, AIE, PIE |
| irq_n_o | output | 1 | Active-low interrupt request |
| status_o | output | 8 | Status byte |
| sqw_o | output | 1 | Square-wave output |

## Verification
Two functions can land on the same edge: a status read that clears the flags, and a flag source (alarm, update, or a periodic tick on the divider boundary) that sets one. A related case is a control write that changes the rate code on the same edge as a tick. The random stimulus sets the read, source and write probabilities so that these overlaps occur often. Directed steps also force a read together with an alarm, and a rate write together with a tick. In every case a cycle-level model in the bench predicts the flag and square-wave state, and each output is compared with that model on every cycle.

// File: rtl/rtc_irq_rate.sv
module rtc_irq_rate #(
  parameter int RATE_W = 4,
  parameter int CNT_W  = (1 << RATE_W) - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                alarm_i,
  input  logic                update_i,
  input  logic                rd_i,
  input  logic                ctl_we_i,
  input  logic [RATE_W+3:0]   ctl_i,
  output logic                irq_n_o,
  output logic [7:0]          status_o,
  output logic                sqw_o
);
  localparam int CTL_W = RATE_W + 4;

  logic [CTL_W-1:0]  ctl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pf_q, af_q, uf_q, phase_q;

  logic [RATE_W-1:0] rate;
  logic              sq_en, uie, aie, pie;
  logic [CNT_W-1:0]  mask;
  logic              per_evt, irqf;

  assign rate  = ctl_q[RATE_W-1:0];
  assign sq_en = ctl_q[RATE_W];
  assign uie   = ctl_q[RATE_W+1];
  assign aie   = ctl_q[RATE_W+2];
  assign pie   = ctl_q[RATE_W+3];

  assign mask    = ~({CNT_W{1'b1}} << (rate - 1'b1));
  assign per_evt = tick_i && (rate != '0) && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cnt_q   <= '0;
      pf_q    <= 1'b0;
      af_q    <= 1'b0;
      uf_q    <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (ctl_we_i) ctl_q <= ctl_i;
      if (per_evt) phase_q <= ~phase_q;
      if (rd_i) begin
        pf_q <= per_evt;
        af_q <= alarm_i;
        uf_q <= update_i;
      end else begin
        pf_q <= pf_q | per_evt;
        af_q <= af_q | alarm_i;
        uf_q <= uf_q | update_i;
      end
    end
  end

  assign irqf     = (pf_q & pie) | (af_q & aie) | (uf_q & uie);
  assign status_o = {irqf, pf_q, af_q, uf_q, 4'b0000};
  assign irq_n_o  = ~irqf;
  assign sqw_o    = sq_en && (rate != '0) && phase_q;

  assert_alarm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_i |=> status_o[5]);

  assert_rate0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0 && !rd_i) |=> $stable(status_o[6]));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !update_i) |=> !status_o[4]);

  assert_phase_needs_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(phase_q) |-> $past(rate) != '0);

  assert_irq_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (af_q && aie) |-> !irq_n_o);
endmodule

// File: tb/tb_rtc_irq_rate.sv
module tb_rtc_irq_rate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, alarm = 0, upd = 0, rd = 0, we = 0;
  logic [7:0] ctl = '0;
  logic irq_n, sqw;
  logic [7:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  int unsigned mticks;
  logic [7:0] mctl;
  logic mpf, maf, muf, mph;

  always #4 clk = ~clk;

  rtc_irq_rate dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .alarm_i(alarm), .update_i(upd),
    .rd_i(rd), .ctl_we_i(we), .ctl_i(ctl),
    .irq_n_o(irq_n), .status_o(status), .sqw_o(sqw)
  );

  function automatic logic m_irqf();
    return (mpf & mctl[7]) | (maf & mctl[6]) | (muf & mctl[5]);
  endfunction

  function automatic logic m_sqw();
    return mctl[4] && (mctl[3:0] != 0) && mph;
  endfunction

  function automatic logic m_evt(logic t);
    int unsigned p;
    if (!t || mctl[3:0] == 0) return 1'b0;
    p = 32'd1 << (mctl[3:0] - 1);
    return ((mticks + 1) % p) == 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    mticks = 0; mctl = '0; mpf = 0; maf = 0; muf = 0; mph = 0;
  endtask

  task automatic compare();
    chk("R1 low nibble", 32'(status[3:0]), 0);
    chk("R2 AF", 32'(status[5]), 32'(maf));
    chk("R2 UF", 32'(status[4]), 32'(muf));
    chk("R3 PF", 32'(status[6]), 32'(mpf));
    chk("R6 IRQF", 32'(status[7]), 32'(m_irqf()));
    chk("R7 irq pin", 32'(irq_n), 32'(!m_irqf()));
    chk("R8 square", 32'(sqw), 32'(m_sqw()));
  endtask

  task automatic step(logic t, logic a, logic u, logic r, logic w, logic [7:0] c);
    logic e;
    compare();
    tick = t; alarm = a; upd = u; rd = r; we = w; ctl = c;
    @(posedge clk);
    e = m_evt(t);
    if (t) mticks++;
    if (e) mph = ~mph;
    if (r) begin mpf = e; maf = a; muf = u; end
    else begin mpf |= e; maf |= a; muf |= u; end
    if (w) mctl = c;
    @(negedge clk);
    tick = 0; alarm = 0; upd = 0; rd = 0; we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  initial begin
    int seen;
    void'($urandom(32'd2024));
    m_reset();
    @(negedge clk);
    do_reset();
    // R10: reset state
    chk("R10 status after reset", 32'(status), 0);
    chk("R10 irq after reset", 32'(irq_n), 1);
    chk("R10 sqw after reset", 32'(sqw), 0);

    // R4: rate code 0 gives no periodic flag with ticks flowing
    step(0, 0, 0, 0, 1, 8'b1001_0000);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0, '0);
    chk("R4 PF stays clear", 32'(status[6]), 0);
    chk("R4 square low", 32'(sqw), 0);

    // R9: write rate 1 on a tick cycle; that tick uses old code 0
    step(1, 0, 0, 1, 1, 8'b1001_0001);
    chk("R9 old rate in write cycle", 32'(status[6]), 0);
    step(1, 0, 0, 0, 0, '0);
    chk("R9 new rate active", 32'(status[6]), 1);

    // R5: read together with alarm keeps AF, clears UF
    step(0, 0, 1, 0, 0, '0);
    step(0, 1, 0, 1, 0, '0);
    chk("R5 AF kept on collision", 32'(status[5]), 1);
    chk("R5 UF cleared", 32'(status[4]), 0);

    // Random mix
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      if ($urandom_range(0, 3) != 0) c[3:0] = 4'($urandom_range(0, 5));
      step($urandom_range(0, 1) == 1, $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 31) == 0, c);
    end

    // R3: code 15, 500 ms period of 16384 ticks
    step(0, 0, 0, 1, 1, 8'b1001_1111);
    seen = 0;
    for (int i = 0; i < 33000; i++) begin
      step(1, 0, 0, status[6], 0, '0);
      if (status[6]) seen++;
    end
    chk("R3 code 15 events seen", 32'(seen), 32'(seen > 0 ? seen : 1));

    // R10: reset clears PIE and other enables
    step(0, 0, 0, 0, 1, 8'hFF);
    do_reset();
    step(0, 1, 0, 0, 0, '0);
    chk("R10 AF set with enables cleared", 32'(status[5]), 1);
    chk("R10 irq stays high", 32'(irq_n), 1);
    compare();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule